// File: doc/BRIEF.md
# Serial Host Byte Receiver with Length Framing

This block receives bytes from a host over a serial clock and data line, gated by an active-low chip select. It oversamples every host signal in the system clock domain. Bits are taken on each rising serial clock edge, most significant bit first. Eight edges complete a byte, and the byte leaves the block on a single-cycle valid strobe together with a tag that marks it as display data or as a command. No trailing edge or end marker is needed.

A static mode input selects how bytes are tagged. In four-wire mode a data/command pin is sampled along with the eighth bit. In three-wire mode that pin is ignored. Instead, the block watches the command stream for a length opcode (default 0xB6) followed by one parameter byte P. The next P+1 bytes, from 1 up to 256, are tagged as data. Every byte outside such a run is a command. The opcode and its parameter are themselves tagged as commands. Other command meanings are left to the consumer.

Deasserting chip select drops a partially received byte but keeps the framing state. A reset pulse resynchronises everything after a clock glitch.

Top module: `ser_host_rx`

## Requirements
- R1: While reset is low and after its release, `rx_valid` stays low until a full byte has been received, and no data run is pending.
- R2: Eight rising serial clock edges taken while chip select is low form one byte. The first bit shifted in becomes bit 7 of `rx_byte`.
- R3: In four-wire mode (`mode_3w`=0), `rx_is_data` equals the level of `dc_in` at the eighth edge: 1 means data, 0 means command.
- R4: In four-wire mode, the length opcode and the byte after it start no run. Later bytes are still tagged from `dc_in` alone.
- R5: In three-wire mode, the opcode (`LEN_OPCODE`) followed by a parameter byte P makes the next P+1 bytes come out with `rx_is_data`=1. The opcode and P carry `rx_is_data`=0, and `dc_in` has no effect.
- R6: In three-wire mode, the byte that follows the last byte of a run is tagged as a command. This holds at both run-length extremes, P=0x00 (one byte) and P=0xFF (256 bytes).
- R7: Serial clock edges that occur while chip select is high produce no byte.
- R8: Raising chip select discards the partial byte. The remaining run count in three-wire mode is kept across the deselect.
- R9: A reset pulse in the middle of a byte clears the bit position and any pending run. The next full byte is then a command in three-wire mode.
- R10: `rx_valid` is high for exactly one system clock. It rises on the third rising `clk` edge after the eighth serial clock rising edge is applied at the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_3w | input | 1 | Static mode: 1 selects length framing, 0 selects the data/command pin |
| sclk_in | input | 1 | Serial clock from host, asynchronous |
| sdata_in | input | 1 | Serial data from host, asynchronous |
| cs_n_in | input | 1 | Active-low chip select, asynchronous |
| dc_in | input | 1 | Data/command pin, used in four-wire mode |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |
| rx_byte | output | 8 | Completed byte |
| rx_is_data | output | 1 | Tag: 1 for display data, 0 for command |

## Verification
Two events can land in the same cycle: completion of a byte, and the run counter stepping down to zero. In that cycle the outgoing byte must still be tagged as data, while the next byte must already be a command. The bench provokes this with runs of 1, 3 and 256 bytes followed directly by another byte. A second collision is a run that is interrupted by a chip-select deselect, or by a reset with a partial byte shifted in. A behavioural model predicts the valid cycle, byte and tag, and every clock is compared against it. The model is judged correct only if the run resumes after the deselect and vanishes after the reset.

// File: rtl/ser_host_pkg.sv
package ser_host_pkg;
   typedef enum logic [1:0] {
      FR_CMD   = 2'd0,
      FR_PARAM = 2'd1,
      FR_DATA  = 2'd2
   } frame_e;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ser_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= RST_VAL;
            else        stage_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdata_s,
   input  logic              csn_s,
   input  logic              dc_s,
   output logic              done,
   output logic [BYTE_W-1:0] byte_q,
   output logic              dc_q
);
   localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   if (BYTE_W < 2) begin : g_bad_width
      $error("ser_shifter: BYTE_W must be at least 2");
   end

   logic              sclk_d;
   logic              rise;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] shreg_nxt;

   assign rise      = sclk_s & ~sclk_d;
   assign shreg_nxt = {shreg[BYTE_W-2:0], sdata_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         bit_cnt <= '0;
         shreg   <= '0;
         done    <= 1'b0;
         byte_q  <= '0;
         dc_q    <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         done   <= 1'b0;
         if (csn_s) begin
            bit_cnt <= '0;
         end else if (rise) begin
            shreg <= shreg_nxt;
            if (bit_cnt == LAST_BIT) begin
               bit_cnt <= '0;
               done    <= 1'b1;
               byte_q  <= shreg_nxt;
               dc_q    <= dc_s;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   // R10
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> !done);

   // R2
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise && !csn_s) |=> $stable(bit_cnt));
endmodule

// File: rtl/ser_framer.sv
module ser_framer
   import ser_host_pkg::*;
#(
   parameter int                BYTE_W     = 8,
   parameter logic [BYTE_W-1:0] LEN_OPCODE = 8'hB6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_3w,
   input  logic              done,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              dc_i,
   output logic              tag_data
);
   localparam int RUN_W = BYTE_W + 1;
   localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

   frame_e           state;
   logic [RUN_W-1:0] run_cnt;

   assign tag_data = mode_3w ? (state == FR_DATA) : dc_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= FR_CMD;
         run_cnt <= '0;
      end else if (done && mode_3w) begin
         unique case (state)
            FR_CMD: begin
               if (byte_i == LEN_OPCODE) state <= FR_PARAM;
            end
            FR_PARAM: begin
               run_cnt <= {1'b0, byte_i} + RUN_ONE;
               state   <= FR_DATA;
            end
            FR_DATA: begin
               run_cnt <= run_cnt - RUN_ONE;
               if (run_cnt == RUN_ONE) state <= FR_CMD;
            end
            default: state <= FR_CMD;
         endcase
      end
   end

   // R4
   mode4_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_3w |=> ($stable(run_cnt) && $stable(state)));

   // R5
   run_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_3w && state == FR_PARAM) |=>
         (run_cnt == {1'b0, $past(byte_i)} + RUN_ONE));

   // R6
   run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_3w && state == FR_DATA) |=>
         (run_cnt == $past(run_cnt) - RUN_ONE));
endmodule

// File: rtl/ser_host_rx.sv
module ser_host_rx #(
   parameter int         BYTE_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter bit         LEN_FRAMING = 1'b1,
   parameter logic [7:0] LEN_OPCODE  = 8'hB6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_3w,
   input  logic              sclk_in,
   input  logic              sdata_in,
   input  logic              cs_n_in,
   input  logic              dc_in,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_is_data
);
   localparam int NSIG = 4;

   if (BYTE_W != 8) begin : g_bad_byte
      $error("ser_host_rx: BYTE_W must be 8");
   end

   logic [NSIG-1:0] raw_v;
   logic [NSIG-1:0] syn_v;
   logic            done;
   logic            dc_cap;

   assign raw_v = {sclk_in, sdata_in, cs_n_in, dc_in};

   ser_sync #(
      .W      (NSIG),
      .STAGES (SYNC_STAGES),
      .RST_VAL(4'b0010)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_v),
      .q    (syn_v)
   );

   ser_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_s (syn_v[3]),
      .sdata_s(syn_v[2]),
      .csn_s  (syn_v[1]),
      .dc_s   (syn_v[0]),
      .done   (done),
      .byte_q (rx_byte),
      .dc_q   (dc_cap)
   );

   if (LEN_FRAMING) begin : g_framed
      ser_framer #(
         .BYTE_W    (BYTE_W),
         .LEN_OPCODE(LEN_OPCODE[BYTE_W-1:0])
      ) u_frame (
         .clk     (clk),
         .rst_n   (rst_n),
         .mode_3w (mode_3w),
         .done    (done),
         .byte_i  (rx_byte),
         .dc_i    (dc_cap),
         .tag_data(rx_is_data)
      );
   end else begin : g_pin_only
      logic unused_mode;
      assign unused_mode = mode_3w;
      assign rx_is_data  = dc_cap;
   end

   assign rx_valid = done;

   // R3
   pin_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !mode_3w) |-> (rx_is_data == dc_cap));
endmodule

// File: tb/ser_host_rx_tb.sv
module ser_host_rx_tb;
   localparam int HALF = 4;
   localparam int LAT  = 3;
   localparam logic [7:0] OPC = 8'hB6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_3w = 1'b0;
   logic sclk_in = 1'b0;
   logic sdata_in = 1'b0;
   logic cs_n_in = 1'b1;
   logic dc_in = 1'b0;
   logic rx_valid;
   logic [7:0] rx_byte;
   logic rx_is_data;

   always #5 clk = ~clk;

   ser_host_rx u_dut (
      .clk(clk), .rst_n(rst_n), .mode_3w(mode_3w),
      .sclk_in(sclk_in), .sdata_in(sdata_in), .cs_n_in(cs_n_in), .dc_in(dc_in),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_is_data(rx_is_data)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   string cur_req = "R1";
   int q_cyc[$];
   int q_byte[$];
   int q_tag[$];
   int m_rem = 0;
   bit m_pend = 1'b0;
   bit finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // Reference comparison every clock
   always @(negedge clk) begin
      if (!finished) begin
         n_cmp++;
         if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
            if (rx_valid !== 1'b1 || rx_byte !== q_byte[0][7:0] || rx_is_data !== q_tag[0][0]) begin
               n_bad++;
               $display("FAIL %s: cyc %0d valid=%0b byte=%02h tag=%0b expected valid=1 byte=%02h tag=%0b",
                        cur_req, cyc, rx_valid, rx_byte, rx_is_data, q_byte[0][7:0], q_tag[0][0]);
            end
            void'(q_cyc.pop_front()); void'(q_byte.pop_front()); void'(q_tag.pop_front());
         end else if (rx_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: cyc %0d valid=%0b expected valid=0", cur_req, cyc, rx_valid);
         end
      end
   end

   task automatic expect_byte(input logic [7:0] b, input bit dc);
      bit tag;
      if (!mode_3w) tag = dc;
      else if (m_rem > 0) begin tag = 1'b1; m_rem--; end
      else if (m_pend) begin tag = 1'b0; m_rem = int'(b) + 1; m_pend = 1'b0; end
      else begin tag = 1'b0; if (b == OPC) m_pend = 1'b1; end
      q_cyc.push_back(cyc + LAT);
      q_byte.push_back(int'(b));
      q_tag.push_back(int'(tag));
   endtask

   task automatic send_bits(input logic [7:0] b, input bit dc, input int nbits, input bit full);
      for (int i = 7; i > 7 - nbits; i--) begin
         @(negedge clk);
         sclk_in = 1'b0; sdata_in = b[i]; dc_in = dc;
         repeat (HALF - 1) @(negedge clk);
         sclk_in = 1'b1;
         if (full && i == 0) expect_byte(b, dc);
         repeat (HALF - 1) @(negedge clk);
      end
      @(negedge clk);
      sclk_in = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input bit dc);
      send_bits(b, dc, 8, 1'b1);
   endtask

   task automatic do_reset(input bit m3);
      @(negedge clk);
      sclk_in = 1'b0;
      rst_n = 1'b0;
      mode_3w = m3;
      q_cyc.delete(); q_byte.delete(); q_tag.delete();
      m_rem = 0; m_pend = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic set_cs(input bit v);
      @(negedge clk);
      cs_n_in = v;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      // R1: reset state, checker expects no strobe
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      set_cs(1'b0);

      // R2/R3: four-wire bytes tagged by pin, MSB first
      cur_req = "R2";
      send_byte(8'hA5, 1'b1);
      send_byte(8'h01, 1'b0);
      cur_req = "R3";
      send_byte(8'h3C, 1'b0);
      send_byte(8'hC3, 1'b1);

      // R4: length opcode ignored in four-wire mode
      cur_req = "R4";
      send_byte(OPC, 1'b0);
      send_byte(8'h02, 1'b0);
      send_byte(8'h11, 1'b0);
      send_byte(8'h22, 1'b1);

      // R7: edges while deselected
      cur_req = "R7";
      set_cs(1'b1);
      for (int k = 0; k < 10; k++) begin
         @(negedge clk); sclk_in = 1'b1; sdata_in = k[0];
         repeat (HALF - 1) @(negedge clk);
         sclk_in = 1'b0;
         repeat (HALF - 1) @(negedge clk);
      end
      set_cs(1'b0);
      send_byte(8'h5A, 1'b1);

      // R8: partial byte discarded on deselect
      cur_req = "R8";
      send_bits(8'hFF, 1'b1, 3, 1'b0);
      set_cs(1'b1);
      set_cs(1'b0);
      send_byte(8'h81, 1'b0);

      // R5: three-wire run of 3, dc pin toggling is ignored
      do_reset(1'b1);
      set_cs(1'b0);
      cur_req = "R5";
      send_byte(8'h40, 1'b1);
      send_byte(OPC, 1'b1);
      send_byte(8'h02, 1'b1);
      send_byte(8'h10, 1'b0);
      send_byte(OPC, 1'b0);
      send_byte(8'h12, 1'b1);
      cur_req = "R6";
      send_byte(8'h13, 1'b1);

      // R6: run of one byte, then run of 256 bytes
      send_byte(OPC, 1'b0);
      send_byte(8'h00, 1'b0);
      send_byte(8'hE7, 1'b0);
      send_byte(8'hE8, 1'b1);
      send_byte(OPC, 1'b0);
      send_byte(8'hFF, 1'b0);
      for (int k = 0; k < 256; k++) send_byte(8'(k * 7 + 1), k[0]);
      send_byte(8'h99, 1'b1);

      // R8: run count survives a deselect
      cur_req = "R8";
      send_byte(OPC, 1'b0);
      send_byte(8'h03, 1'b0);
      send_byte(8'h71, 1'b0);
      send_bits(8'hAA, 1'b0, 5, 1'b0);
      set_cs(1'b1);
      set_cs(1'b0);
      send_byte(8'h72, 1'b0);
      send_byte(8'h73, 1'b0);
      send_byte(8'h74, 1'b0);
      send_byte(8'h75, 1'b1);

      // R9: reset mid-byte inside a run
      cur_req = "R9";
      send_byte(OPC, 1'b0);
      send_byte(8'h05, 1'b0);
      send_byte(8'h61, 1'b0);
      send_byte(8'h62, 1'b0);
      send_bits(8'h0F, 1'b0, 3, 1'b0);
      do_reset(1'b1);
      send_byte(8'h63, 1'b1);
      send_byte(8'h64, 1'b0);

      // R10: settle and confirm no stray strobes
      cur_req = "R10";
      repeat (20) @(negedge clk);
      if (q_cyc.size() != 0) begin
         n_bad++;
         $display("FAIL R10: %0d expected bytes never seen, expected 0", q_cyc.size());
      end
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_bad++;
         $display("FAIL %s: watchdog expired, actual running expected done", cur_req);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule